// File: doc/BRIEF.md
# Scatter-Gather DMA Channel

This block is one DMA channel that follows a chain of chunk descriptors held in memory and copies the data each descriptor names. Software places the address of the first descriptor on `head_addr`, picks the loop mode on `cyclic_en` and pulses `start`. The channel reads the four words of a descriptor over its memory port. It checks the descriptor. It then copies the chunk one beat at a time: it reads a source word and writes that word to the destination. After the chunk it moves to the next descriptor. Control pulses can hold the channel at a beat boundary, release it, or discard all remaining work. The residue output gives the bytes still to move in the chunk in flight.

A descriptor is four 32-bit words at consecutive word addresses: source address, destination address, control, next pointer. The control word carries the following fields. Bits 15:0 hold the chunk size in bytes. Bits 17:16 hold the width code, where 0, 1 and 2 mean 1, 2 and 4 bytes per beat. Bits 21:18 hold the burst length minus one. Bit 22 makes the source step. Bit 23 makes the destination step. Bit 24 makes the chunk device-paced. A chunk that is device-paced starts each burst only while `drq` is high. Ring mode lets a chain run forever: a zero next pointer sends the channel back to the head descriptor.

Top module: `sg_dma_channel`

## Requirements
- R1: After reset the channel is idle. `mem_req`, `done_irq` and `err` are low and `residue` is 0.
- R2: After `start` the channel reads four words at `head_addr`, `+4`, `+8` and `+12`. It follows non-zero next pointers. In non-ring mode a zero next pointer returns it to idle with a single one-cycle `done_irq` pulse for the whole chain.
- R3: Each beat reads the source address and then writes the word returned by that read to the destination address. `mem_size` carries the descriptor's width code.
- R4: When a step flag is set, its address advances by the beat width (1, 2 or 4 bytes) after each beat. When the flag is clear, the address stays fixed. A chunk of size S and width w makes exactly S/w writes.
- R5: A chunk with the device flag starts no burst while `drq` is low. A burst that has started runs to the end of its burst length, which is control bits 21:18 plus one beats. The channel then checks `drq` again.
- R6: In ring mode a zero next pointer jumps back to the latched head descriptor, and `done_irq` pulses at the end of every chunk. The channel keeps running until it is aborted.
- R7: A `pause` takes effect at the next beat boundary. While paused, `paused` is high, `mem_req` is low and no write occurs. After `resume` the chunk finishes with every beat in order.
- R8: After `abort` the channel is idle on the next cycle, `residue` is 0 and no further write is issued.
- R9: `residue` equals the chunk size less the bytes already written in the current chunk. In ring mode it counts only the current chunk.
- R10: `head_addr` and `cyclic_en` are latched at `start`. A `start` or a change to those inputs while busy has no effect on the running transfer.
- R11: A descriptor whose size is 0, whose size is not a multiple of the width, or whose width code is 3 raises `err` and returns the channel to idle with no data beat.
- R12: A request that `mem_ready` has not accepted keeps its address and direction until it is accepted, unless `abort` withdraws it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, used only when idle |
| head_addr | input | AW | Byte address of the first descriptor |
| cyclic_en | input | 1 | Ring mode select, latched at start |
| pause | input | 1 | Hold request pulse |
| resume | input | 1 | Release pulse |
| abort | input | 1 | Discard all work |
| drq | input | 1 | Device request level |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the request |
| mem_size | output | 2 | Width code of the access |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| busy | output | 1 | Channel active |
| paused | output | 1 | Channel held |
| done_irq | output | 1 | One-cycle completion pulse |
| err | output | 1 | Bad descriptor seen; cleared by the next start |
| residue | output | SIZE_W | Bytes left in the current chunk |

## Verification
The assertions rely on the memory port returning exactly one `mem_rvalid` for each accepted read, one or more cycles after acceptance, and never returning one otherwise. They also rely on control inputs being single-cycle pulses. The bench memory answers each accepted read on the next cycle. It can accept requests every cycle or on alternate cycles. It never changes a descriptor while that descriptor is being fetched, and `abort` is only driven as a pulse.

// File: rtl/sg_dma_channel.sv
`timescale 1ns/1ps
module sg_dma_channel #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int SIZE_W  = 16,
  parameter int BURST_W = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     head_addr,
  input  logic              cyclic_en,
  input  logic              pause,
  input  logic              resume,
  input  logic              abort,
  input  logic              drq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic              paused,
  output logic              done_irq,
  output logic              err,
  output logic [SIZE_W-1:0] residue
);
  localparam int WC_LSB   = SIZE_W;
  localparam int BL_LSB   = SIZE_W + 2;
  localparam int SINC_BIT = BL_LSB + BURST_W;
  localparam int DINC_BIT = SINC_BIT + 1;
  localparam int DEV_BIT  = SINC_BIT + 2;
  localparam int CTRL_W   = DEV_BIT + 1;
  localparam int BEAT_W   = BURST_W + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_CHECK, S_BURST,
    S_RD, S_RWAIT, S_WR, S_NEXT, S_PAUSE
  } st_t;

  st_t               st, ret_st;
  logic [AW-1:0]     head, dptr, src, dst, nxt;
  logic [CTRL_W-1:0] ctrl;
  logic [DW-1:0]     data;
  logic [SIZE_W-1:0] rem;
  logic [BEAT_W-1:0] beats;
  logic [1:0]        widx;
  logic              cyc, pause_pend, rd_pend;

  wire [SIZE_W-1:0]  c_size  = ctrl[SIZE_W-1:0];
  wire [1:0]         c_wcode = ctrl[WC_LSB+1:WC_LSB];
  wire [BURST_W-1:0] c_burst = ctrl[BL_LSB+BURST_W-1:BL_LSB];
  wire               c_sinc  = ctrl[SINC_BIT];
  wire               c_dinc  = ctrl[DINC_BIT];
  wire               c_dev   = ctrl[DEV_BIT];
  wire [3:0]         wbytes  = 4'd1 << c_wcode;
  wire               bad     = (c_size == '0) || (c_wcode == 2'd3) ||
                               ((c_size & SIZE_W'(wbytes - 4'd1)) != '0);

  assign mem_req   = (st == S_FREQ || st == S_RD || st == S_WR) && !abort;
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_FREQ) ? dptr + AW'({widx, 2'b00}) :
                     (st == S_RD)   ? src : dst;
  assign mem_size  = (st == S_FREQ) ? 2'd2 : c_wcode;
  assign mem_wdata = data;
  assign busy      = (st != S_IDLE);
  assign paused    = (st == S_PAUSE);
  assign residue   = rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;   ret_st <= S_BURST;
      head <= '0;     dptr <= '0;   src <= '0;  dst <= '0;  nxt <= '0;
      ctrl <= '0;     data <= '0;   rem <= '0;  beats <= '0; widx <= '0;
      cyc <= 1'b0;    pause_pend <= 1'b0;       rd_pend <= 1'b0;
      done_irq <= 1'b0; err <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (mem_req && mem_ready && !mem_we) rd_pend <= 1'b1;
      else if (mem_rvalid)                 rd_pend <= 1'b0;
      if (st != S_IDLE) begin
        if (resume)     pause_pend <= 1'b0;
        else if (pause) pause_pend <= 1'b1;
      end
      if (abort && st != S_IDLE) begin
        st <= S_IDLE;
        rem <= '0;
        pause_pend <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start && !rd_pend) begin
            head <= head_addr;  dptr <= head_addr;  cyc <= cyclic_en;
            widx <= '0;  err <= 1'b0;  pause_pend <= 1'b0;
            st <= S_FREQ;
          end
          S_FREQ: if (mem_ready) st <= S_FWAIT;
          S_FWAIT: if (mem_rvalid) begin
            case (widx)
              2'd0:    src  <= mem_rdata[AW-1:0];
              2'd1:    dst  <= mem_rdata[AW-1:0];
              2'd2:    ctrl <= mem_rdata[CTRL_W-1:0];
              default: nxt  <= mem_rdata[AW-1:0];
            endcase
            widx <= widx + 2'd1;
            st <= (widx == 2'd3) ? S_CHECK : S_FREQ;
          end
          S_CHECK: if (bad) begin
            err <= 1'b1;
            st <= S_IDLE;
          end else begin
            rem <= c_size;
            st <= S_BURST;
          end
          S_BURST: if (pause_pend) begin
            ret_st <= S_BURST;
            st <= S_PAUSE;
          end else if (!c_dev || drq) begin
            beats <= BEAT_W'(c_burst) + BEAT_W'(1);
            st <= S_RD;
          end
          S_RD: if (mem_ready) st <= S_RWAIT;
          S_RWAIT: if (mem_rvalid) begin
            data <= mem_rdata;
            st <= S_WR;
          end
          S_WR: if (mem_ready) begin
            rem <= rem - SIZE_W'(wbytes);
            if (c_sinc) src <= src + AW'(wbytes);
            if (c_dinc) dst <= dst + AW'(wbytes);
            beats <= beats - BEAT_W'(1);
            if (rem == SIZE_W'(wbytes))   st <= S_NEXT;
            else if (beats == BEAT_W'(1)) st <= S_BURST;
            else if (pause_pend) begin
              ret_st <= S_RD;
              st <= S_PAUSE;
            end else st <= S_RD;
          end
          S_NEXT: begin
            widx <= '0;
            if (cyc) done_irq <= 1'b1;
            if (nxt == '0) begin
              if (cyc) begin
                dptr <= head;
                st <= S_FREQ;
              end else begin
                done_irq <= 1'b1;
                st <= S_IDLE;
              end
            end else begin
              dptr <= nxt;
              st <= S_FREQ;
            end
          end
          S_PAUSE: if (resume) st <= ret_st;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sg_dma_channel_chk.sv
`timescale 1ns/1ps
module sg_dma_channel_chk #(
  parameter int AW     = 32,
  parameter int SIZE_W = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              abort,
  input logic              busy,
  input logic              paused,
  input logic              done_irq,
  input logic              err,
  input logic [SIZE_W-1:0] residue,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr
);
  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !abort) |=>
      (abort || (mem_req && $stable(mem_addr) && $stable(mem_we))));

  assert_paused_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !mem_req);

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> (!busy && residue == '0));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  assert_err_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);

  assert_residue_falls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(residue) != '0 && residue != $past(residue))
      |-> (residue < $past(residue)));
endmodule

bind sg_dma_channel sg_dma_channel_chk #(.AW(AW), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/sg_dma_channel_test.sv
`timescale 1ns/1ps
module sg_dma_channel_test;
  localparam int AW = 32, DW = 32, SW = 16;
  // row: [96] slow ready, [95:64] src, [63:32] dst, [31:0] control word
  localparam logic [96:0] VEC [6] = '{
    {1'b0, 32'h200, 32'h600, 32'h00C60010},
    {1'b1, 32'h240, 32'h640, 32'h00C20020},
    {1'b0, 32'h280, 32'h680, 32'h008E000C},
    {1'b0, 32'h2C0, 32'h6C0, 32'h004A000C},
    {1'b1, 32'h300, 32'h700, 32'h00FD0008},
    {1'b0, 32'h343, 32'h743, 32'h00C00003}
  };

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, start, cyclic_en, pause, resume, abort, drq;
  logic [AW-1:0] head_addr;
  logic mem_req, mem_we, mem_ready, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic busy, paused, done_irq, err;
  logic [SW-1:0] residue;

  sg_dma_channel uut (.*);

  logic [31:0] mem [256];
  logic [31:0] log_a [1024];
  logic [31:0] log_d [1024];
  int wr_cnt = 0, done_cnt = 0, errors = 0, checks = 0;
  logic tick = 0, slow = 0;
  bit finished = 0;

  assign mem_ready = slow ? tick : 1'b1;
  always @(posedge clk) tick <= ~tick;
  always @(posedge clk) begin
    mem_rvalid <= mem_req && mem_ready && !mem_we;
    mem_rdata  <= mem[mem_addr[9:2]];
    if (mem_req && mem_ready && mem_we) begin
      if (wr_cnt < 1024) begin
        log_a[wr_cnt] <= mem_addr;
        log_d[wr_cnt] <= mem_wdata;
      end
      wr_cnt <= wr_cnt + 1;
    end
    if (done_irq) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] s, d, c, n);
    mem[a>>2] = s; mem[(a>>2)+1] = d; mem[(a>>2)+2] = c; mem[(a>>2)+3] = n;
  endtask

  task automatic go(input logic [31:0] h, input logic cy);
    @(negedge clk); head_addr = h; cyclic_en = cy; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) pause = 1; else if (which == 1) resume = 1; else abort = 1;
    @(negedge clk); pause = 0; resume = 0; abort = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  task automatic wait_wr(input int target);
    for (int k = 0; k < 5000 && wr_cnt < target; k++) @(negedge clk);
  endtask

  // expected writes for a single chunk, from the descriptor fields
  task automatic check_chunk(input string tag, input int base, input logic [31:0] s, d, c);
    int w, n;
    w = 1 << c[17:16];
    n = c[15:0] / w;
    for (int i = 0; i < n; i++) begin
      chk({tag, " addr"}, log_a[base+i], d + (c[23] ? i*w : 0));
      chk({tag, " data"}, log_d[base+i], mem[((s + (c[22] ? i*w : 0)) >> 2) & 255]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int b, dn;
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 | i;
    rst_n = 0; start = 0; cyclic_en = 0; pause = 0; resume = 0; abort = 0;
    drq = 0; head_addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 residue", residue, 0);
    chk("R1 err/done", {err, done_irq}, 0);

    // table of single-chunk transfers (R3 R4; slow rows exercise R12)
    for (int r = 0; r < 6; r++) begin
      slow = VEC[r][96];
      put_desc(32'h40, VEC[r][95:64], VEC[r][63:32], VEC[r][31:0], 0);
      b = wr_cnt; dn = done_cnt;
      go(32'h40, 0);
      wait_idle();
      @(negedge clk);
      chk("R4 write count", wr_cnt - b, VEC[r][15:0] / (1 << VEC[r][17:16]));
      check_chunk("R3 R4 R12 row", b, VEC[r][95:64], VEC[r][63:32], VEC[r][31:0]);
      chk("R2 done pulses", done_cnt - dn, 1);
      chk("R11 no err", err, 0);
    end
    slow = 0;

    // bad descriptors (R11)
    foreach (VEC[r]) if (r < 3) begin
      logic [31:0] bc;
      bc = (r == 0) ? 32'h00C20006 : (r == 1) ? 32'h00C30008 : 32'h00C20000;
      put_desc(32'h40, 32'h200, 32'h600, bc, 0);
      b = wr_cnt; dn = done_cnt;
      go(32'h40, 0);
      wait_idle();
      @(negedge clk);
      chk("R11 err set", err, 1);
      chk("R11 no writes", wr_cnt - b, 0);
      chk("R11 no done", done_cnt - dn, 0);
    end

    // two-descriptor chain (R2)
    put_desc(32'h40, 32'h200, 32'h600, 32'h00C20008, 32'h60);
    put_desc(32'h60, 32'h280, 32'h700, 32'h00C20004, 0);
    b = wr_cnt; dn = done_cnt;
    go(32'h40, 0);
    wait_idle();
    @(negedge clk);
    chk("R2 chain writes", wr_cnt - b, 3);
    chk("R2 second chunk addr", log_a[b+2], 32'h700);
    chk("R2 single done", done_cnt - dn, 1);

    // ring mode then abort (R6 R8 R9)
    b = wr_cnt; dn = done_cnt;
    go(32'h40, 1);
    for (int k = 0; k < 3000 && done_cnt - dn < 4; k++) @(negedge clk);
    chk("R6 still busy", busy, 1);
    chk("R6 done per chunk", (done_cnt - dn) >= 4, 1);
    chk("R6 wrapped to head", log_a[b+3], 32'h600);
    chk("R6 wrapped data", log_d[b+4], mem[(32'h204) >> 2]);
    pulse(2);
    chk("R8 idle after abort", busy, 0);
    chk("R8 residue zero", residue, 0);
    dn = wr_cnt;
    repeat (20) @(negedge clk);
    chk("R8 no more writes", wr_cnt - dn, 0);

    // pause and resume (R7 R9)
    put_desc(32'h40, 32'h200, 32'h800, 32'h00CE0040, 0);
    b = wr_cnt; dn = done_cnt;
    go(32'h40, 0);
    wait_wr(b + 5);
    pulse(0);
    repeat (5) @(negedge clk);
    chk("R7 paused", paused, 1);
    chk("R7 no request", mem_req, 0);
    begin
      int n0;
      n0 = wr_cnt - b;
      repeat (30) @(negedge clk);
      chk("R7 no writes while paused", wr_cnt - b, n0);
      chk("R9 residue paused", residue, 64 - 4*n0);
    end
    pulse(1);
    wait_idle();
    @(negedge clk);
    chk("R7 all beats after resume", wr_cnt - b, 16);
    check_chunk("R7 order", b, 32'h200, 32'h800, 32'h00CE0040);
    chk("R7 done", done_cnt - dn, 1);

    // device pacing (R5 R9)
    put_desc(32'h40, 32'h200, 32'h900, 32'h01C60010, 0);
    b = wr_cnt;
    drq = 0;
    go(32'h40, 0);
    repeat (40) @(negedge clk);
    chk("R5 no burst without drq", wr_cnt - b, 0);
    chk("R9 residue full", residue, 16);
    drq = 1;
    wait_wr(b + 1);
    drq = 0;
    repeat (30) @(negedge clk);
    chk("R5 one burst only", wr_cnt - b, 2);
    chk("R9 residue after burst", residue, 8);
    drq = 1;
    wait_idle();
    @(negedge clk);
    chk("R5 finish with drq", wr_cnt - b, 4);
    drq = 0;

    // configuration latched at start (R10)
    put_desc(32'h40, 32'h200, 32'hA00, 32'h00C20010, 0);
    put_desc(32'h80, 32'h240, 32'hB00, 32'h00C20004, 0);
    b = wr_cnt; dn = done_cnt;
    go(32'h40, 0);
    @(negedge clk);
    head_addr = 32'h80; cyclic_en = 1; start = 1;
    @(negedge clk); start = 0;
    wait_idle();
    @(negedge clk);
    chk("R10 only first chain", wr_cnt - b, 4);
    chk("R10 dst of first", log_a[b+3], 32'hA0C);
    chk("R10 not ring", done_cnt - dn, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule